// File: doc/BRIEF.md
# Card Command Frame Transmitter

This block sends one card command over a single serial command line. Software stages the command in a five-byte transmit buffer through a byte write port. The first byte written is the command index, and the next four bytes are the argument. A rising edge on a start control then launches the frame.

The block sends the 40 staged bits most significant bit first. As those bits go out, it builds a 7-bit CRC over them in hardware. After the data it sends the CRC and a closing '1'. The line moves only on clock-enable ticks, so the card clock divider stays outside the block.

While a frame is in flight, a lock output is high. During that time, buffer writes, pointer resets and new start edges are ignored. When the frame ends, the lock drops and an end-of-command flag rises. The flag stays set until software clears it. An interrupt output shows the flag gated by an enable.

Top module: `cmd_frame_tx`

## Requirements
- R1: Each accepted byte write goes to the next of five slots, starting at slot 0. Slot 0 is the command index and slots 1..4 are the argument from most to least significant. After slot 4 the write pointer wraps to slot 0, so a sixth write replaces the index.
- R2: A frame starts only on a rising edge of `start_en` seen while `lock` is low. `lock` is high from the next clock. Holding `start_en` high does not start a second frame.
- R3: While `lock` is high, `wr_en` and `ptr_rst` have no effect on the staged bytes or on the write pointer. A new `start_en` edge does not restart the frame in progress.
- R4: One tick after the closing bit has been driven, `lock` goes low and `done_flag` goes high on the same clock edge. `done_flag` then stays high until a `clr_done` pulse. If a set and a clear arrive together, the set wins.
- R5: `ptr_rst` with `lock` low returns the write pointer to slot 0, so the next byte written is the command index. A `ptr_rst` in the same cycle as a write drops that write. Each frame reads from slot 0 onward.
- R6: The line is driven by a register. On each clock where `tick` is high during a frame, it takes the next frame bit. The frame is 48 bits: the 40 staged bits MSB first, slot 0 first, then 7 CRC bits MSB first, then a '1'. Outside a frame the line is high.
- R7: The CRC uses the generator x^7+x^3+1, starts from all zeros, and covers the 40 staged bits in line order. For example, 40 00 00 00 00 gives 4A, and 48 00 00 01 AA gives 43.
- R8: `irq` equals `done_flag AND irq_en` at all times.
- R9: Clocks with `tick` low do not advance the frame. The line and the lock hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Bit-rate clock enable |
| wr_en | input | 1 | Stage-buffer byte write strobe |
| wr_data | input | 8 | Byte to stage |
| ptr_rst | input | 1 | Return the write pointer to slot 0 |
| start_en | input | 1 | Start control; its rising edge launches a frame |
| clr_done | input | 1 | Write-one-to-clear pulse for `done_flag` |
| irq_en | input | 1 | Interrupt enable |
| cmd_line | output | 1 | Serial command line, idles high |
| lock | output | 1 | Frame in progress; writes are locked |
| done_flag | output | 1 | End-of-command flag |
| irq | output | 1 | Gated end-of-command interrupt |

## Verification
Some results appear one clock after their stimulus: `lock` after an accepted start edge, and a new `cmd_line` value after each tick edge. The drop of `lock` and the rise of `done_flag` come together, 49 ticks after the frame starts. `irq` follows `done_flag` and `irq_en` with no delay. The bench model applies each effect at the same rising edge as the design and compares all four outputs 2 ns after every edge, away from both the edge and the input changes. The bits the design actually drove are also collected and compared against frames whose CRC was worked out beforehand.

// File: rtl/cmdtx_pkg.sv
package cmdtx_pkg;

  localparam int CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_TAPS = 7'h09;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_CRC,
    ST_STOP,
    ST_TAIL
  } tx_state_e;

  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] cur,
                                                 input logic din);
    logic fb;
    fb = din ^ cur[CRC_W-1];
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
  endfunction

  function automatic logic [CRC_W-1:0] crc7_shift_out(input logic [CRC_W-1:0] cur);
    return {cur[CRC_W-2:0], 1'b0};
  endfunction

endpackage

// File: rtl/cmdtx_stage.sv
module cmdtx_stage #(
  parameter int BYTES  = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ptr_rst,
  input  logic              locked,
  input  logic              rd_restart,
  input  logic              rd_adv,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam int PTR_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(BYTES - 1);

  logic [BYTES-1:0][BYTE_W-1:0] mem_q;
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic wr_accept, rst_accept;

  assign rst_accept = ptr_rst && !locked;
  assign wr_accept  = wr_en && !locked && !ptr_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
    end else if (rst_accept) begin
      wptr_q <= '0;
    end else if (wr_accept) begin
      wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    end
  end

  generate
    for (genvar s = 0; s < BYTES; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n) mem_q[s] <= '0;
        else if (wr_accept && (wptr_q == PTR_W'(s))) mem_q[s] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr_q <= '0;
    end else if (rd_restart || rst_accept) begin
      rptr_q <= '0;
    end else if (rd_adv) begin
      rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    end
  end

  assign rd_byte = mem_q[rptr_q];

  p_locked_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && (wr_en || ptr_rst)) |=> ($stable(mem_q) && $stable(wptr_q)));

  p_restart_slot0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_restart |=> (rptr_q == '0));

endmodule

// File: rtl/cmdtx_crc7.sv
module cmdtx_crc7 (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic feed_en,
  input  logic feed_bit,
  input  logic out_en,
  output logic crc_msb
);
  import cmdtx_pkg::*;

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       crc_q <= '0;
    else if (clear)   crc_q <= '0;
    else if (feed_en) crc_q <= crc7_step(crc_q, feed_bit);
    else if (out_en)  crc_q <= crc7_shift_out(crc_q);
  end

  assign crc_msb = crc_q[CRC_W-1];

  p_crc_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_q == '0));

  p_crc_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !feed_en && !out_en) |=> $stable(crc_q));

endmodule

// File: rtl/cmdtx_ctrl.sv
module cmdtx_ctrl #(
  parameter int BYTES  = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_en,
  input  logic              clr_done,
  input  logic [BYTE_W-1:0] rd_byte,
  input  logic              crc_msb,
  output logic              start_go,
  output logic              rd_adv,
  output logic              crc_feed,
  output logic              crc_out,
  output logic              data_bit,
  output logic              end_evt,
  output logic              locked,
  output logic              line_q,
  output logic              done_q
);
  import cmdtx_pkg::*;

  localparam int DATA_BITS = BYTES * BYTE_W;
  localparam int PH_W      = $clog2(DATA_BITS + 1);
  localparam int BI_W      = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  tx_state_e        state_q;
  logic [PH_W-1:0]  ph_q;
  logic [BI_W-1:0]  bit_q;
  logic             start_q;
  logic             ph_last;

  assign locked   = (state_q != ST_IDLE);
  assign start_go = start_en && !start_q && !locked;
  assign data_bit = rd_byte[BYTE_W-1-int'(bit_q)];
  assign crc_feed = tick && (state_q == ST_DATA);
  assign crc_out  = tick && (state_q == ST_CRC);
  assign rd_adv   = crc_feed && (bit_q == BI_W'(BYTE_W - 1));
  assign end_evt  = tick && (state_q == ST_TAIL);
  assign ph_last  = (state_q == ST_DATA) ? (ph_q == PH_W'(DATA_BITS - 1))
                                         : (ph_q == PH_W'(CRC_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      bit_q   <= '0;
      line_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_go) begin
            state_q <= ST_DATA;
            ph_q    <= '0;
            bit_q   <= '0;
          end
        end
        ST_DATA: begin
          if (tick) begin
            line_q <= data_bit;
            bit_q  <= (bit_q == BI_W'(BYTE_W - 1)) ? '0 : bit_q + 1'b1;
            if (ph_last) begin
              state_q <= ST_CRC;
              ph_q    <= '0;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        ST_CRC: begin
          if (tick) begin
            line_q <= crc_msb;
            if (ph_last) state_q <= ST_STOP;
            else         ph_q    <= ph_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (tick) begin
            line_q  <= 1'b1;
            state_q <= ST_TAIL;
          end
        end
        ST_TAIL: begin
          if (tick) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (end_evt)  done_q <= 1'b1;
    else if (clr_done) done_q <= 1'b0;
  end

  p_lock_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> locked);

  p_line_idle_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked || state_q == ST_TAIL) |-> line_q);

  p_done_at_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> done_q);

  p_no_tick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !tick) |=> ($stable(line_q) && locked));

endmodule

// File: rtl/cmd_frame_tx.sv
module cmd_frame_tx #(
  parameter int BYTES  = 5,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ptr_rst,
  input  logic              start_en,
  input  logic              clr_done,
  input  logic              irq_en,
  output logic              cmd_line,
  output logic              lock,
  output logic              done_flag,
  output logic              irq
);
  logic [BYTE_W-1:0] rd_byte;
  logic start_go, rd_adv, crc_feed, crc_out, data_bit, end_evt, crc_msb;

  cmdtx_stage #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .ptr_rst    (ptr_rst),
    .locked     (lock),
    .rd_restart (start_go),
    .rd_adv     (rd_adv),
    .rd_byte    (rd_byte)
  );

  cmdtx_crc7 u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_go),
    .feed_en  (crc_feed),
    .feed_bit (data_bit),
    .out_en   (crc_out),
    .crc_msb  (crc_msb)
  );

  cmdtx_ctrl #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .start_en (start_en),
    .clr_done (clr_done),
    .rd_byte  (rd_byte),
    .crc_msb  (crc_msb),
    .start_go (start_go),
    .rd_adv   (rd_adv),
    .crc_feed (crc_feed),
    .crc_out  (crc_out),
    .data_bit (data_bit),
    .end_evt  (end_evt),
    .locked   (lock),
    .line_q   (cmd_line),
    .done_q   (done_flag)
  );

  assign irq = done_flag && irq_en;

  p_end_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (done_flag && !lock));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done_flag && irq_en));

endmodule

// File: tb/cmd_frame_tx_tb_top.sv
module cmd_frame_tx_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, ptr_rst = 0;
  logic start_en = 0, clr_done = 0, irq_en = 0;
  logic [7:0] wr_data = 0;
  logic cmd_line, lock, done_flag, irq;

  int checks = 0, errors = 0, tick_div = 1, tcnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cmd_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .ptr_rst(ptr_rst), .start_en(start_en), .clr_done(clr_done), .irq_en(irq_en),
    .cmd_line(cmd_line), .lock(lock), .done_flag(done_flag), .irq(irq));

  // ---------------- reference model ----------------
  logic [7:0]  m_fifo [5];
  int          m_wp, m_cnt;
  logic        m_line, m_lock, m_done, m_prev, m_emit, m_go, m_old_lock, m_fin;
  logic [47:0] m_frame, dut_cap;

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [46:0] r;
    r = {d, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  function automatic logic [47:0] make_frame(input logic [39:0] d);
    return {d, ref_crc(d), 1'b1};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) m_fifo[i] = 0;
      m_wp = 0; m_cnt = 0; m_line = 1; m_lock = 0; m_done = 0; m_prev = 0; m_emit = 0;
    end else begin
      m_go = start_en && !m_prev && !m_lock;
      m_prev = start_en;
      m_emit = 0;
      m_old_lock = m_lock;
      m_fin = 0;
      if (!m_old_lock) begin
        if (ptr_rst) m_wp = 0;
        else if (wr_en) begin m_fifo[m_wp] = wr_data; m_wp = (m_wp + 1) % 5; end
      end
      if (m_old_lock && tick) begin
        if (m_cnt < 48) begin m_line = m_frame[47 - m_cnt]; m_cnt++; m_emit = 1; end
        else begin m_lock = 0; m_fin = 1; end
      end
      if (m_fin) m_done = 1; else if (clr_done) m_done = 0;
      if (m_go) begin
        m_frame = make_frame({m_fifo[0], m_fifo[1], m_fifo[2], m_fifo[3], m_fifo[4]});
        m_lock = 1; m_cnt = 0;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare 2 ns after each edge, away from input changes at the falling edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      check("R6 cmd_line", cmd_line, m_line);
      check("R2/R3 lock", lock, m_lock);
      check("R4 done_flag", done_flag, m_done);
      check("R8 irq", irq, m_done && irq_en);
      if (m_emit) dut_cap = {dut_cap[46:0], cmd_line};
    end
  end

  always @(negedge clk) begin
    if (tick_div <= 1) tick <= 1;
    else begin
      tcnt = (tcnt + 1) % tick_div;
      tick <= (tcnt == 0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b; @(negedge clk); wr_en = 0;
  endtask
  task automatic pulse_start;
    @(negedge clk); start_en = 1; @(negedge clk); start_en = 0;
  endtask
  task automatic load5(input logic [39:0] d);
    for (int i = 0; i < 5; i++) wr(d[39 - 8*i -: 8]);
  endtask
  task automatic wait_unlock;
    while (lock) @(negedge clk);
    cyc(2);
  endtask
  task automatic clear_done;
    @(negedge clk); clr_done = 1; @(negedge clk); clr_done = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hang expected completion");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    // reset state
    check("R6 reset line high", cmd_line, 1);
    check("R2 reset lock low", lock, 0);
    check("R4 reset done low", done_flag, 0);
    check("R8 reset irq low", irq, 0);

    // R7: first known frame, tick every clock
    load5(40'h40_0000_0000);
    pulse_start;
    check("R2 lock after start", lock, 1);
    wait_unlock;
    check("R7 frame 40 00 00 00 00", dut_cap, 48'h40_0000_0000_95);
    check("R4 done after frame", done_flag, 1);

    // R8: interrupt gating, then R4 clear
    irq_en = 1; cyc(2);
    check("R8 irq enabled", irq, 1);
    clear_done;
    check("R4 done cleared", done_flag, 0);
    check("R8 irq after clear", irq, 0);

    // R7 and R9: second known frame with a sparse tick; start edge held high (R2)
    tick_div = 3;
    load5(40'h48_0000_01AA);
    @(negedge clk); start_en = 1;
    cyc(30);
    check("R2 held level keeps lock", lock, 1);
    // R3: writes, pointer reset and start edges are ignored during the frame
    wr(8'hFF); wr(8'hEE);
    @(negedge clk); ptr_rst = 1; @(negedge clk); ptr_rst = 0;
    wait_unlock;
    check("R7 frame 48 00 00 01 AA", dut_cap, 48'h48_0000_01AA_87);
    cyc(20);
    check("R2 held level no restart", lock, 0);
    start_en = 0;
    // Locked writes were dropped: resend the same bytes untouched
    pulse_start;
    wait_unlock;
    check("R3 locked writes ignored", dut_cap, 48'h48_0000_01AA_87);
    check("R6 line idles high", cmd_line, 1);

    // R9: tick held low mid-frame
    tick_div = 1;
    clear_done;
    pulse_start;
    cyc(10);
    tick_div = 1000; tcnt = 1;
    cyc(3);
    begin
      logic l0; l0 = cmd_line;
      cyc(20);
      check("R9 line holds without tick", cmd_line, l0);
      check("R9 lock holds without tick", lock, 1);
    end
    tick_div = 1;
    wait_unlock;

    // R1: six writes wrap the pointer so slot 0 is replaced
    @(negedge clk); ptr_rst = 1; @(negedge clk); ptr_rst = 0;
    load5(40'h11_2233_4455);
    wr(8'h77);
    pulse_start;
    wait_unlock;
    check("R1 pointer wrap", dut_cap, make_frame(40'h77_2233_4455));

    // R5: pointer reset after two writes, and same-cycle write dropped
    wr(8'hAA); wr(8'hBB);
    @(negedge clk); ptr_rst = 1; wr_en = 1; wr_data = 8'hCC; @(negedge clk); ptr_rst = 0; wr_en = 0;
    load5(40'h51_0000_0200);
    pulse_start;
    wait_unlock;
    check("R5 pointer reset", dut_cap, make_frame(40'h51_0000_0200));

    // R4: set wins over a same-cycle clear
    clear_done;
    pulse_start;
    while (lock) begin
      @(negedge clk); clr_done = 1;
    end
    clr_done = 0;
    cyc(1);
    check("R4 set beats clear", done_flag, 1);

    cyc(5);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule